// File: doc/BRIEF.md
# Per-Lane Variable Shift Unit

This unit shifts every lane of a 256-bit source vector by an amount taken from the matching lane of a 256-bit count vector. It supports three operations: a logical left shift on 32-bit lanes, a logical left shift on 64-bit lanes, and an arithmetic right shift on 32-bit lanes. The operation comes from an opcode byte and an element-width bit. A vector-length bit picks either the full 256 bits or the low 128 bits. The whole unsigned count of each lane is used. A count that reaches the lane width gives zero for a left shift. For an arithmetic shift it gives a lane filled with the sign bit. Any unsupported encoding raises an illegal-encoding flag and returns a zero result.

When `REG_OUT` is 1, a small output state machine registers the result and has three states. `ST_IDLE` means no result is being presented. `ST_DONE` means a legal request was accepted on the last edge. `ST_FAULT` means an illegal request was accepted on the last edge. From any state, a cycle with `valid_in` high moves to `ST_DONE` when the encoding is legal and to `ST_FAULT` when it is not. A cycle with `valid_in` low moves back to `ST_IDLE`. When `REG_OUT` is 0, the unit is purely combinational and both flags follow `valid_in` directly.

Top module: `vshift_unit`

## Requirements
- R1: Opcode 0x47 with `wide_elem`=0 shifts each of the 32-bit lanes left by its own count and fills the vacated low bits with 0.
- R2: Opcode 0x47 with `wide_elem`=1 shifts each of the 64-bit lanes left by its own count and fills the vacated low bits with 0.
- R3: Opcode 0x46 with `wide_elem`=0 shifts each 32-bit lane right by its own count and fills the vacated high bits with that lane's original bit 31.
- R4: For a left shift, the result lane is 0 whenever the full unsigned count lane is at least the lane width (32 or 64), even when the count's low 5 or 6 bits are small.
- R5: For the arithmetic right shift, a full unsigned count above 31 makes all 32 result bits equal to the source lane's bit 31.
- R6: With `vlen_full`=0, result bits 255:128 are 0 and the low 128 bits follow R1 to R5. With `vlen_full`=1, all lanes are computed.
- R7: An encoding is illegal when the opcode is anything other than 0x46 or 0x47, or when the opcode is 0x46 with `wide_elem`=1. An accepted illegal request gives `illegal_out`=1, `valid_out`=0 and a result of 0.
- R8: With `REG_OUT`=1, a legal request with `valid_in`=1 gives `valid_out`=1, `illegal_out`=0 and its result exactly one clock later. Back-to-back requests are each presented in turn.
- R9: After a cycle with `valid_in`=0, `valid_out` and `illegal_out` are 0 and `result` keeps its previous value.
- R10: During and right after reset, `valid_out`, `illegal_out` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Request strobe |
| opcode | input | 8 | Operation byte (0x47 shift left, 0x46 arithmetic shift right) |
| wide_elem | input | 1 | Lane width select: 0 for 32-bit lanes, 1 for 64-bit lanes |
| vlen_full | input | 1 | 1 for 256-bit vectors, 0 for 128-bit vectors (upper half cleared) |
| src_a | input | VLEN | Data vector to shift |
| src_cnt | input | VLEN | Per-lane unsigned shift counts |
| valid_out | output | 1 | Legal result present |
| illegal_out | output | 1 | Illegal encoding flagged |
| result | output | VLEN | Shifted vector |

## Verification
The bench builds the unit with its defaults: `VLEN`=256 and `REG_OUT`=1. This gives eight 32-bit lanes, four 64-bit lanes and the registered state machine. Each operation is swept over counts from 0 to 71 in both vector lengths, with the count staggered across lanes. As a result, every lane sees the values at width minus one, at the width itself and past it, while its neighbours hold different counts. Separate vectors place counts whose upper bits are set but whose low bits are small, which exposes any truncation of the count. The same configuration also covers illegal encodings, back-to-back requests and the hold behaviour of the output register.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

    localparam logic [7:0] OPC_SHL = 8'h47;
    localparam logic [7:0] OPC_SAR = 8'h46;

    typedef enum logic [1:0] {
        OPK_SHL32 = 2'd0,
        OPK_SHL64 = 2'd1,
        OPK_SAR32 = 2'd2,
        OPK_BAD   = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } out_state_t;

endpackage

// File: rtl/vshift_decode.sv
module vshift_decode
    import vshift_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       wide_elem,
    output op_kind_t   kind
);

    always_comb begin
        unique case (opcode)
            OPC_SHL: kind = wide_elem ? OPK_SHL64 : OPK_SHL32;
            OPC_SAR: kind = wide_elem ? OPK_BAD   : OPK_SAR32;
            default: kind = OPK_BAD;
        endcase
    end

endmodule

// File: rtl/vshift_lane.sv
module vshift_lane #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] data,
    input  logic [LANE_W-1:0] cnt,
    input  logic              arith,
    output logic [LANE_W-1:0] res
);

    localparam int SH_W = $clog2(LANE_W);

    logic [SH_W-1:0] sh;
    logic            over;
    logic            fill;

    // Every count bit above the shift field takes part in the range test.
    assign sh   = cnt[SH_W-1:0];
    assign over = |cnt[LANE_W-1:SH_W];
    assign fill = arith & data[LANE_W-1];

    always_comb begin
        if (over) begin
            res = {LANE_W{fill}};
        end else if (arith) begin
            res = LANE_W'($signed(data) >>> sh);
        end else begin
            res = data << sh;
        end
    end

endmodule

// File: rtl/vshift_datapath.sv
module vshift_datapath
    import vshift_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_cnt,
    input  op_kind_t        kind,
    input  logic            vlen_full,
    output logic [VLEN-1:0] res
);

    localparam int N32  = VLEN / 32;
    localparam int N64  = VLEN / 64;
    localparam int HALF = VLEN / 2;

    logic [VLEN-1:0] r32;
    logic [VLEN-1:0] r64;
    logic [VLEN-1:0] sel;
    logic            is_sar;

    assign is_sar = (kind == OPK_SAR32);

    generate
        for (genvar g = 0; g < N32; g++) begin : g_l32
            vshift_lane #(.LANE_W(32)) u_lane (
                .data  (src_a[g*32 +: 32]),
                .cnt   (src_cnt[g*32 +: 32]),
                .arith (is_sar),
                .res   (r32[g*32 +: 32])
            );
        end
        for (genvar g = 0; g < N64; g++) begin : g_l64
            vshift_lane #(.LANE_W(64)) u_lane (
                .data  (src_a[g*64 +: 64]),
                .cnt   (src_cnt[g*64 +: 64]),
                .arith (1'b0),
                .res   (r64[g*64 +: 64])
            );
        end
    endgenerate

    always_comb begin
        unique case (kind)
            OPK_SHL32, OPK_SAR32: sel = r32;
            OPK_SHL64:            sel = r64;
            default:              sel = '0;
        endcase
        res = sel;
        if (!vlen_full) begin
            res[VLEN-1:HALF] = '0;
        end
    end

endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
    import vshift_pkg::*;
#(
    parameter int VLEN    = 256,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_in,
    input  logic [7:0]      opcode,
    input  logic            wide_elem,
    input  logic            vlen_full,
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_cnt,
    output logic            valid_out,
    output logic            illegal_out,
    output logic [VLEN-1:0] result
);

    op_kind_t        kind;
    logic [VLEN-1:0] dp_res;
    logic            bad;

    vshift_decode u_dec (
        .opcode    (opcode),
        .wide_elem (wide_elem),
        .kind      (kind)
    );

    vshift_datapath #(.VLEN(VLEN)) u_dp (
        .src_a     (src_a),
        .src_cnt   (src_cnt),
        .kind      (kind),
        .vlen_full (vlen_full),
        .res       (dp_res)
    );

    assign bad = (kind == OPK_BAD);

    generate
        if (REG_OUT) begin : g_reg
            out_state_t      state_q;
            out_state_t      state_d;
            logic [VLEN-1:0] res_q;

            always_comb begin
                if (!valid_in) begin
                    state_d = ST_IDLE;
                end else if (bad) begin
                    state_d = ST_FAULT;
                end else begin
                    state_d = ST_DONE;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    state_q <= ST_IDLE;
                    res_q   <= '0;
                end else begin
                    state_q <= state_d;
                    if (valid_in) begin
                        res_q <= dp_res;
                    end
                end
            end

            always_comb begin
                unique case (state_q)
                    ST_DONE: begin
                        valid_out   = 1'b1;
                        illegal_out = 1'b0;
                    end
                    ST_FAULT: begin
                        valid_out   = 1'b0;
                        illegal_out = 1'b1;
                    end
                    default: begin
                        valid_out   = 1'b0;
                        illegal_out = 1'b0;
                    end
                endcase
                result = res_q;
            end
        end else begin : g_comb
            always_comb begin
                valid_out   = valid_in & ~bad;
                illegal_out = valid_in & bad;
                result      = dp_res;
            end
        end
    endgenerate

endmodule

// File: rtl/vshift_unit_chk.sv
module vshift_unit_chk #(
    parameter int VLEN    = 256,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid_in,
    input logic [7:0]      opcode,
    input logic            wide_elem,
    input logic            vlen_full,
    input logic [VLEN-1:0] src_a,
    input logic [VLEN-1:0] src_cnt,
    input logic            valid_out,
    input logic            illegal_out,
    input logic [VLEN-1:0] result
);

    logic legal;
    logic sar_far;

    assign legal   = (opcode == 8'h47) || ((opcode == 8'h46) && !wide_elem);
    assign sar_far = valid_in && (opcode == 8'h46) && !wide_elem && (src_cnt[31:5] != '0);

    generate
        if (REG_OUT) begin : g_chk
            // R8
            legal_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
                valid_in && legal |=> valid_out && !illegal_out);

            // R7
            illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                valid_in && !legal |=> illegal_out && !valid_out && (result == '0));

            // R9
            idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_in |=> !valid_out && !illegal_out && $stable(result));

            // R6
            upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                valid_in && !vlen_full |=> (result[VLEN-1:VLEN/2] == '0));

            // R5
            sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sar_far |=> (result[31:0] == {32{$past(src_a[31])}}));
        end
    endgenerate

endmodule

bind vshift_unit vshift_unit_chk #(.VLEN(VLEN), .REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_in    (valid_in),
    .opcode      (opcode),
    .wide_elem   (wide_elem),
    .vlen_full   (vlen_full),
    .src_a       (src_a),
    .src_cnt     (src_cnt),
    .valid_out   (valid_out),
    .illegal_out (illegal_out),
    .result      (result)
);

// File: tb/vshift_unit_tb.sv
`timescale 1ns/1ps
module vshift_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [7:0]   opcode = 8'h00;
    logic         wide_elem = 1'b0;
    logic         vlen_full = 1'b1;
    logic [255:0] src_a = '0;
    logic [255:0] src_cnt = '0;
    logic         valid_out;
    logic         illegal_out;
    logic [255:0] result;

    int n_chk = 0;
    int n_bad = 0;
    logic [255:0] last_res = '0;

    always #4 clk = ~clk;

    vshift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .opcode(opcode),
        .wide_elem(wide_elem), .vlen_full(vlen_full), .src_a(src_a),
        .src_cnt(src_cnt), .valid_out(valid_out), .illegal_out(illegal_out),
        .result(result)
    );

    function automatic logic [255:0] model(input logic [7:0] opc, input logic w,
                                           input logic v, input logic [255:0] a,
                                           input logic [255:0] c);
        logic [255:0] r;
        r = '0;
        if (opc == 8'h47 && w) begin
            for (int i = 0; i < 4; i++) begin
                logic [63:0] x, n;
                x = a[i*64 +: 64];
                n = c[i*64 +: 64];
                r[i*64 +: 64] = (n > 64'd63) ? 64'd0 : 64'(x * (64'd1 << n[5:0]));
            end
        end else if (opc == 8'h47) begin
            for (int i = 0; i < 8; i++) begin
                logic [31:0] x, n;
                x = a[i*32 +: 32];
                n = c[i*32 +: 32];
                r[i*32 +: 32] = (n > 32'd31) ? 32'd0 : 32'(x * (32'd1 << n[4:0]));
            end
        end else if (opc == 8'h46 && !w) begin
            for (int i = 0; i < 8; i++) begin
                logic [31:0] x, n;
                logic [63:0] ext;
                x = a[i*32 +: 32];
                n = c[i*32 +: 32];
                ext = {{32{x[31]}}, x};
                r[i*32 +: 32] = (n > 32'd31) ? {32{x[31]}} : ext[n[4:0] +: 32];
            end
        end
        if (!v) r[255:128] = '0;
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] opc, input logic w, input logic v,
                         input logic [255:0] a, input logic [255:0] c, input string req);
        logic [255:0] exp;
        logic legal;
        legal = (opc == 8'h47) || (opc == 8'h46 && !w);
        exp = legal ? model(opc, w, v, a, c) : '0;
        @(negedge clk);
        opcode = opc; wide_elem = w; vlen_full = v; src_a = a; src_cnt = c;
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        check(result == exp, req, result, exp);
        if (legal)
            check(valid_out && !illegal_out, "R8 flags", {254'd0, valid_out, illegal_out}, 256'd2);
        else
            check(!valid_out && illegal_out, "R7 flags", {254'd0, valid_out, illegal_out}, 256'd1);
        last_res = result;
    endtask

    task automatic hold_check();
        @(negedge clk);
        check(!valid_out && !illegal_out && result == last_res, "R9", result, last_res);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [255:0] a, c;
        string tag;
        repeat (3) @(negedge clk);
        // R10: outputs during reset
        check(!valid_out && !illegal_out && result == '0, "R10 in reset",
              {result[253:0], valid_out, illegal_out}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid_out && !illegal_out && result == '0, "R10 after reset",
              {result[253:0], valid_out, illegal_out}, '0);

        // Sweep: R1, R2, R3 in both lengths (R6 for the short one)
        for (int m = 0; m < 3; m++) begin
            for (int v = 0; v < 2; v++) begin
                for (int k = 0; k < 72; k++) begin
                    for (int i = 0; i < 8; i++)
                        a[i*32 +: 32] = (32'h9E3779B9 * 32'(k + 1)) ^ (32'h01010101 * 32'(i))
                                        ^ (((k + i) % 2 == 1) ? 32'h8000_0000 : 32'h0);
                    if (m == 1) begin
                        for (int i = 0; i < 4; i++) c[i*64 +: 64] = 64'((k + i*17) % 72);
                    end else begin
                        for (int i = 0; i < 8; i++) c[i*32 +: 32] = 32'((k + i*9) % 72);
                    end
                    if (v == 0) tag = "R6";
                    else if (m == 0) tag = "R1";
                    else if (m == 1) tag = "R2";
                    else tag = "R3";
                    issue((m == 2) ? 8'h46 : 8'h47, m == 1, v == 1, a, c, tag);
                    if (k % 8 == 0) hold_check();
                end
            end
        end

        // R4 / R5: counts with upper bits set and small low bits
        c = {32'hFFFF_FFE1, 32'h8000_0002, 32'h0001_0000, 32'h0000_0100,
             32'h0000_0020, 32'h0000_0040, 32'h4000_0001, 32'h0000_0003};
        a = {32'h8123_4567, 32'h7FFF_FFFF, 32'hF000_000F, 32'h0000_0001,
             32'h8000_0000, 32'h1234_5678, 32'hC000_0003, 32'h0F0F_F0F0};
        issue(8'h47, 1'b0, 1'b1, a, c, "R4 lanes32");
        issue(8'h46, 1'b0, 1'b1, a, c, "R5 sar large");
        issue(8'h46, 1'b0, 1'b1, ~a, c, "R5 sar large inv");
        c = {64'h0000_0001_0000_0001, 64'h8000_0000_0000_0003,
             64'h0000_0000_0000_0100, 64'h0000_0000_0000_0005};
        issue(8'h47, 1'b1, 1'b1, a, c, "R4 lanes64");
        hold_check();

        // R7: illegal encodings after a nonzero result
        a = {8{32'hDEAD_BEEF}}; c = '0;
        issue(8'h47, 1'b0, 1'b1, a, c, "R1 before illegal");
        issue(8'h46, 1'b1, 1'b1, a, c, "R7 sar wide");
        issue(8'h45, 1'b0, 1'b1, a, c, "R7 op45");
        issue(8'h00, 1'b1, 1'b1, a, c, "R7 op00");
        issue(8'hFF, 1'b0, 1'b0, a, c, "R7 opFF");
        issue(8'h07, 1'b0, 1'b1, a, c, "R7 op07");
        hold_check();

        // R8: back-to-back requests
        @(negedge clk);
        opcode = 8'h47; wide_elem = 1'b0; vlen_full = 1'b1;
        src_a = {8{32'h0000_0001}}; src_cnt = {32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0};
        valid_in = 1'b1;
        @(negedge clk);
        a = {32'h80, 32'h40, 32'h20, 32'h10, 32'h8, 32'h4, 32'h2, 32'h1};
        check(result == a && valid_out, "R8 first", result, a);
        opcode = 8'h46; src_a = {8{32'h8000_0000}}; src_cnt = {8{32'd4}};
        @(negedge clk);
        valid_in = 1'b0;
        a = {8{32'hF800_0000}};
        check(result == a && valid_out, "R8 second", result, a);
        last_res = result;
        hold_check();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule